// File: doc/BRIEF.md
# Thread-Interleaved Private RAM

This block is a single-port synchronous RAM for a pipeline that has been C-slowed, meaning C independent data streams share the logic and are interleaved one per clock in round-robin order. To preserve the meaning of the original single-stream design, every stream must see a memory of its own. The block builds that from one physical array that is C times deeper than the logical memory. A free-running thread counter supplies the high address bits, and the address presented in the current cycle supplies the low bits. Writes from one stream therefore can never land in another stream's words.

The surrounding pipeline presents one access per clock: an address, write data and a write enable. That access belongs to the thread whose index is on `cur_tid` in the same cycle. Read data comes back one cycle later, together with the index of the thread that issued it. The array has no reset and is written in a form that maps onto FPGA block RAM. The counter and the response tag reset synchronously.

Top module: `cslow_ram`

## Requirements
- R1: Each of the THREADS threads owns 2**AW words. Addresses 0 through 2**AW-1 are all usable by every thread, and the physical array holds THREADS*2**AW words.
- R2: While `rst` is high at a rising edge, `cur_tid` becomes 0 and `rd_valid` becomes 0. The first cycle after reset is driven by thread 0.
- R3: Outside reset, `cur_tid` rises by one at every clock and wraps from THREADS-1 to 0. It never takes a value of THREADS or above, including when THREADS is not a power of two.
- R4: An access with `we`=1 stores `wdata` at word `addr` of the thread on `cur_tid` in that cycle. A later read of `addr` by the same thread returns that value.
- R5: A write by one thread is never visible to any other thread, including at the same `addr`.
- R6: Read data has one cycle of latency. The cycle after an access, `rdata` holds the addressed word and `rd_tid` holds the `cur_tid` of the issuing cycle.
- R7: When a read and a write hit the same word in the same cycle, `rdata` returns the contents from before the write.
- R8: An access with `we`=0 leaves the memory unchanged, whatever is on `wdata`.
- R9: `rd_valid` is 1 in every cycle that follows a cycle with `rst` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address within the current thread's memory |
| wdata | input | DW | Data to store |
| we | input | 1 | Write enable for the current access |
| cur_tid | output | TW | Thread that owns the access in this cycle |
| rdata | output | DW | Read data from the previous cycle's access |
| rd_tid | output | TW | Thread that issued the access returned on `rdata` |
| rd_valid | output | 1 | `rdata` and `rd_tid` reflect a non-reset access |

## Verification
The hardest case to reach from the ports is showing isolation. Several threads must hold different values at the same logical address, and then each must read back only its own. The stimulus fills every word of every thread, with data that encodes the owning thread and address, and then sweeps the reads with the counter in a different phase. A second scenario lets one thread write a word while the next threads read that same address in the following cycles. The default of three threads also drives the counter through its non-power-of-two wrap, where the top quarter of the address space must stay untouched.

// File: rtl/cslow_pkg.sv
package cslow_pkg;

  // Width of a thread index; at least one bit so ports stay legal for C=1.
  function automatic int tid_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cslow_thread_ctr.sv
module cslow_thread_ctr #(
  parameter int THREADS = 3,
  parameter int TW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] tid
);

  localparam logic [TW-1:0] LAST = TW'(THREADS - 1);

  generate
    if (THREADS == (1 << TW)) begin : g_pow2
      // Natural rollover already wraps at THREADS.
      always_ff @(posedge clk) begin
        if (rst) tid <= '0;
        else     tid <= tid + 1'b1;
      end
    end else begin : g_modulo
      // Explicit wrap keeps the unused upper index values out of reach.
      always_ff @(posedge clk) begin
        if (rst)              tid <= '0;
        else if (tid == LAST) tid <= '0;
        else                  tid <= tid + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/cslow_addr_join.sv
module cslow_addr_join #(
  parameter int TW = 2,
  parameter int AW = 4
) (
  input  logic [TW-1:0]    tid,
  input  logic [AW-1:0]    addr,
  output logic [TW+AW-1:0] phys
);

  // Thread index on top: each thread owns one contiguous 2**AW slice.
  assign phys = {tid, addr};

endmodule

// File: rtl/cslow_ram_core.sv
module cslow_ram_core #(
  parameter int WORDS = 48,
  parameter int IW    = 6,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  // Read-first single port; no reset so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata <= mem[idx];
  end

endmodule

// File: rtl/cslow_ram.sv
module cslow_ram #(
  parameter  int THREADS = 3,
  parameter  int AW      = 4,
  parameter  int DW      = 16,
  localparam int TW      = cslow_pkg::tid_bits(THREADS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [TW-1:0] cur_tid,
  output logic [DW-1:0] rdata,
  output logic [TW-1:0] rd_tid,
  output logic          rd_valid
);

  localparam int DEPTH = 1 << AW;
  localparam int WORDS = THREADS * DEPTH;
  localparam int IW    = TW + AW;

  logic [IW-1:0] phys;

  cslow_thread_ctr #(.THREADS(THREADS), .TW(TW)) u_ctr (
    .clk (clk),
    .rst (rst),
    .tid (cur_tid)
  );

  cslow_addr_join #(.TW(TW), .AW(AW)) u_join (
    .tid  (cur_tid),
    .addr (addr),
    .phys (phys)
  );

  cslow_ram_core #(.WORDS(WORDS), .IW(IW), .DW(DW)) u_core (
    .clk   (clk),
    .we    (we & ~rst),
    .idx   (phys),
    .wdata (wdata),
    .rdata (rdata)
  );

  // Response tag travels alongside the one-cycle read.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_tid   <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_tid   <= cur_tid;
      rd_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/cslow_ram_chk.sv
module cslow_ram_chk #(
  parameter int THREADS = 3,
  parameter int TW      = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] cur_tid,
  input logic [TW-1:0] rd_tid,
  input logic          rd_valid
);

  localparam logic [TW-1:0] LAST = TW'(THREADS - 1);

  AST_TID_RANGE: assert property (@(posedge clk) disable iff (rst)
    cur_tid <= LAST);                                                    // R3

  AST_TID_STEP: assert property (@(posedge clk) disable iff (rst)
    (cur_tid != LAST) |=> (cur_tid == $past(cur_tid) + 1'b1));           // R3

  AST_TID_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cur_tid == LAST) |=> (cur_tid == '0));                              // R3

  AST_RESP_TAG: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_tid == $past(cur_tid)));                            // R6

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> rd_valid);                                                  // R9

endmodule

bind cslow_ram cslow_ram_chk #(.THREADS(THREADS), .TW(TW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cur_tid  (cur_tid),
  .rd_tid   (rd_tid),
  .rd_valid (rd_valid)
);

// File: tb/sim_cslow_ram.sv
module sim_cslow_ram;

  localparam int THREADS = 3;
  localparam int AW      = 4;
  localparam int DW      = 16;
  localparam int TW      = 2;
  localparam int DEPTH   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [TW-1:0] cur_tid;
  logic [DW-1:0] rdata;
  logic [TW-1:0] rd_tid;
  logic          rd_valid;

  int errors = 0;
  int checks = 0;
  int exp_tid = 0;
  bit finished = 1'b0;

  logic [DW-1:0] shadow [THREADS][DEPTH];
  bit            known  [THREADS][DEPTH];

  always #10 clk = ~clk;  // 50 MHz

  cslow_ram #(.THREADS(THREADS), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
    .cur_tid(cur_tid), .rdata(rdata), .rd_tid(rd_tid), .rd_valid(rd_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int t, input int a, input int salt);
    return DW'((t << 12) ^ (a << 4) ^ salt);
  endfunction

  // One access: called at a negedge; returns at the negedge after the response.
  task automatic access(input bit w, input int a, input logic [DW-1:0] d,
                        input string req);
    int t;
    check(cur_tid == TW'(exp_tid), "R3 cur_tid", 32'(cur_tid), 32'(exp_tid));
    t = exp_tid;
    we = w; addr = AW'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    check(rd_valid == 1'b1, "R9 rd_valid", 32'(rd_valid), 32'd1);
    check(rd_tid == TW'(t), "R6 rd_tid", 32'(rd_tid), 32'(t));
    if (known[t][a])
      check(rdata == shadow[t][a], req, 32'(rdata), 32'(shadow[t][a]));
    if (w) begin
      shadow[t][a] = d;
      known[t][a]  = 1'b1;
    end
    exp_tid = (exp_tid + 1) % THREADS;
    we = 1'b0;
  endtask

  task automatic t_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1; we = 1'b0;
    repeat (cycles) @(negedge clk);
    check(cur_tid == '0, "R2 cur_tid in reset", 32'(cur_tid), 32'd0);
    check(rd_valid == 1'b0, "R2 rd_valid in reset", 32'(rd_valid), 32'd0);
    rst = 1'b0;
    exp_tid = 0;
    for (int t = 0; t < THREADS; t++)
      for (int a = 0; a < DEPTH; a++) known[t][a] = 1'b0;
  endtask

  // Every thread writes every word, including address 0 and the top address.
  task automatic t_fill_all();
    for (int i = 0; i < THREADS * DEPTH; i++)
      access(1'b1, i / THREADS, pattern(exp_tid, i / THREADS, 16'h5), "R1 fill");
  endtask

  // Read back with the counter phase shifted so threads swap addresses.
  task automatic t_readback_all();
    access(1'b0, 0, '0, "R4 R5 readback");
    for (int i = 0; i < THREADS * DEPTH; i++)
      access(1'b0, (i * 7) % DEPTH, 16'hFFFF, "R4 R5 readback");
    for (int i = 0; i < THREADS; i++)
      access(1'b0, DEPTH - 1, '0, "R1 top address");
  endtask

  // One thread writes a word, the following threads read that same address.
  task automatic t_isolate();
    for (int r = 0; r < 2 * THREADS; r++) begin
      access(1'b1, 9, pattern(exp_tid, 9, 16'hA0 + r), "R5 write");
      for (int k = 1; k < THREADS; k++)
        access(1'b0, 9, '0, "R5 other thread");
    end
  endtask

  // Read and write of one word in the same cycle returns the old contents.
  task automatic t_read_first();
    for (int i = 0; i < 2 * THREADS; i++)
      access(1'b1, 3, pattern(exp_tid, 3, 16'h300 + i), "R7 read-first");
    for (int i = 0; i < THREADS; i++)
      access(1'b0, 3, '0, "R4 after read-first");
  endtask

  // Disabled writes with live data must not disturb anything.
  task automatic t_no_write();
    for (int i = 0; i < 3 * THREADS; i++)
      access(1'b0, i % 4, 16'hDEAD, "R8 we low");
    for (int i = 0; i < 3 * THREADS; i++)
      access(1'b0, i % 4, '0, "R8 unchanged");
  endtask

  initial begin
    t_reset(3);
    t_fill_all();
    t_readback_all();
    t_isolate();
    t_read_first();
    t_no_write();
    t_reset(2);
    t_fill_all();
    t_isolate();
    t_readback_all();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule